// File: doc/BRIEF.md
# Precise-Exception Rollback Queue

This block keeps an in-order record of every instruction that leaves issue. For each one it saves the value the destination register held before the instruction was dispatched. Execution units later report completion against the slot tag handed out at issue, and may flag a fault with that report. The oldest record leaves the queue once it has completed cleanly. A fault is only acted on when its record becomes the oldest. At that point the queue walks backwards from the youngest record and replays the saved values through two fixed-point and two floating-point restore lanes per cycle. The register files are then back in the state they held just before the faulting instruction was issued.

Stores take a slot like any other instruction. They are considered complete at issue. Their address and data sit in a companion buffer, and each store is released to memory once every older record has finished without a fault. A store that was not released before a rollback is dropped. For a store issue, `issue_old` carries the store data and `issue_addr` the address. Class codes on `issue_class` are 0 = fixed-point, 1 = floating-point, 2 = condition/branch, 3 = store.

Top module: `rb_history_queue`

## Requirements
- R1: The queue holds at most 6 records. After reset it is empty and `issue_ready` is 1. With 6 records present, `issue_ready` is 0 for every class.
- R2: At most 4 records of class 0 (fixed-point) may be present. At that limit `issue_ready` is 0 for class 0 and stays 1 for classes 1 to 3 while total room remains.
- R3: `issue_tag` shows the slot the next accepted issue takes. Slots are handed out in order 0,1,2,3,4,5 and then wrap back to 0.
- R4: Only the oldest record retires, and only once it has completed without a fault (a store only after its release). At most one record retires per cycle, and `retire_tag` reports the slot. Records retire in issue order even when they complete out of order.
- R5: `exception_taken` pulses for one cycle when the oldest record has completed with its fault bit set. A fault on a younger record has no effect while an older record is still present.
- R6: After a fault is taken, every record from the youngest down to and including the faulting one is restored in reverse issue order. Lane 0 of a class always carries a younger record than lane 1 in the same cycle. Applying the writes in that order returns both register files to their values before the faulting issue.
- R7: A rollback cycle restores at most 2 fixed-point and 2 floating-point records. It stops at the first record, walking from the youngest, whose class lanes are already used. The number of rollback cycles follows from that rule.
- R8: `issue_ready` is 0 from the cycle `exception_taken` pulses until the rollback completes. Afterwards the queue is empty and the next tag is the faulting record's slot.
- R9: A store is written to memory only once every older record has completed without a fault. Stores are written one per cycle in issue order, with the address and data given at their issue.
- R10: A store not yet written when a fault is taken is discarded and never reaches the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_class | input | 2 | Class code: 0 fixed, 1 float, 2 cond/branch, 3 store |
| issue_dst | input | 5 | Destination register index |
| issue_old | input | 32 | Prior destination value, or store data |
| issue_addr | input | 32 | Store address (stores only) |
| issue_ready | output | 1 | Issue accepted this cycle when valid |
| issue_tag | output | 3 | Slot assigned to the offered instruction |
| finish_valid | input | 1 | Completion report |
| finish_tag | input | 3 | Slot of the completing instruction |
| finish_exc | input | 1 | Completion carries a fault |
| retire_valid | output | 1 | Oldest record leaves the queue |
| retire_tag | output | 3 | Slot of the retiring record |
| exception_taken | output | 1 | One-cycle pulse: rollback starts |
| rfx_valid | output | 2 | Fixed-point restore lane enables |
| rfx_idx | output | 2x5 | Fixed-point restore register indices |
| rfx_data | output | 2x32 | Fixed-point restore values |
| rfl_valid | output | 2 | Floating-point restore lane enables |
| rfl_idx | output | 2x5 | Floating-point restore register indices |
| rfl_data | output | 2x32 | Floating-point restore values |
| mem_wr_valid | output | 1 | Store released to memory |
| mem_wr_addr | output | 32 | Released store address |
| mem_wr_data | output | 32 | Released store data |

## Verification
A store release and the retirement of the record ahead of it land in the same cycle. Once the older record completes cleanly, the same cycle both frees the head and clears the store for memory. The bench provokes this by parking two stores behind an unfinished fixed-point operation and then completing that operation. A monitor counts the cycles in which a retirement and a memory write appear together, and the bench compares the count and the order of released addresses with the values expected from the release rule. Rollback is swept over every fixed/float mix of a full queue with overlapping destinations. The predicted cycle count is computed from the lane rule and the final register state is compared with the state before the faulting issue.

// File: rtl/rbq_pkg.sv
// Package: shared class codes and state encoding for the rollback queue.
// Assumes: class codes are fixed by the issue interface (2 bits).
package rbq_pkg;

    typedef enum logic [1:0] {
        CL_FIX = 2'd0,
        CL_FLT = 2'd1,
        CL_CCB = 2'd2,
        CL_STO = 2'd3
    } iclass_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_UNWIND = 1'b1
    } qstate_e;

endpackage

// File: rtl/rbq_alloc.sv
// Module: rbq_alloc
// Keeps the head and tail slot pointers, total occupancy and fixed-point
// occupancy, and forms the issue handshake.
// Assumes: retire and unwind never coincide, and issue never coincides with
// unwind (the top blocks issue while unwinding).
module rbq_alloc #(
    parameter int DEPTH   = 6,
    parameter int TAG_W   = 3,
    parameter int FIX_MAX = 4,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             block,
    input  logic             issue_valid,
    input  logic             issue_is_fix,
    input  logic             retire,
    input  logic             retire_is_fix,
    input  logic             unwind,
    input  logic [CNT_W-1:0] unwind_n,
    input  logic [CNT_W-1:0] unwind_fix_n,
    output logic             issue_ready,
    output logic             issue_fire,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] fix_occ
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] FIXM_C  = CNT_W'(FIX_MAX);

    logic [CNT_W-1:0] occ_nx;
    logic [CNT_W-1:0] fix_nx;
    logic [TAG_W-1:0] tail_nx;
    logic [TAG_W-1:0] head_nx;

    // Purpose: decide whether the offered instruction may enter this cycle.
    always_comb begin
        issue_ready = !block && (occ < DEPTH_C) &&
                      !(issue_is_fix && (fix_occ >= FIXM_C));
        issue_fire  = issue_valid && issue_ready;
    end

    // Purpose: next-state arithmetic for pointers and occupancy counters.
    always_comb begin
        occ_nx = occ + CNT_W'(issue_fire) - CNT_W'(retire)
                 - (unwind ? unwind_n : '0);
        fix_nx = fix_occ + CNT_W'(issue_fire && issue_is_fix)
                 - CNT_W'(retire && retire_is_fix)
                 - (unwind ? unwind_fix_n : '0);
        if (unwind)
            tail_nx = TAG_W'((int'(tail) + DEPTH - int'(unwind_n)) % DEPTH);
        else if (issue_fire)
            tail_nx = TAG_W'((int'(tail) + 1) % DEPTH);
        else
            tail_nx = tail;
        head_nx = retire ? TAG_W'((int'(head) + 1) % DEPTH) : head;
    end

    // Purpose: register pointers and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            occ     <= '0;
            fix_occ <= '0;
        end else begin
            head    <= head_nx;
            tail    <= tail_nx;
            occ     <= occ_nx;
            fix_occ <= fix_nx;
        end
    end

endmodule

// File: rtl/rbq_unwind_pick.sv
// Module: rbq_unwind_pick
// Combinational selector for one rollback cycle. Walks from the youngest
// record toward the head and assigns fixed and float records to restore
// lanes in that order, stopping at the first record whose class has no free
// lane. Records of other classes pass without using a lane.
// Assumes: occ counts the records between head and tail.
module rbq_unwind_pick
    import rbq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int TAG_W  = 3,
    parameter int CNT_W  = 3,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int LANES  = 2
) (
    input  logic [TAG_W-1:0]                   tail,
    input  logic [CNT_W-1:0]                   occ,
    input  logic [DEPTH-1:0][1:0]              cls,
    input  logic [DEPTH-1:0][IDX_W-1:0]        dst,
    input  logic [DEPTH-1:0][DATA_W-1:0]       oldv,
    output logic [CNT_W-1:0]                   take_n,
    output logic [CNT_W-1:0]                   take_fix_n,
    output logic [DEPTH-1:0]                   take_mask,
    output logic [LANES-1:0]                   fx_valid,
    output logic [LANES-1:0][IDX_W-1:0]        fx_idx,
    output logic [LANES-1:0][DATA_W-1:0]       fx_data,
    output logic [LANES-1:0]                   fl_valid,
    output logic [LANES-1:0][IDX_W-1:0]        fl_idx,
    output logic [LANES-1:0][DATA_W-1:0]       fl_data
);

    // Purpose: greedy youngest-first lane assignment for this cycle.
    always_comb begin : pick
        int   nfx;
        int   nfl;
        int   n;
        int   p;
        logic halt;
        nfx       = 0;
        nfl       = 0;
        n         = 0;
        halt      = 1'b0;
        take_mask = '0;
        fx_valid  = '0;
        fx_idx    = '0;
        fx_data   = '0;
        fl_valid  = '0;
        fl_idx    = '0;
        fl_data   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            p = (int'(tail) + 2 * DEPTH - 1 - i) % DEPTH;
            if (!halt && (i < int'(occ))) begin
                if (cls[p] == CL_FIX) begin
                    if (nfx < LANES) begin
                        fx_valid[nfx] = 1'b1;
                        fx_idx[nfx]   = dst[p];
                        fx_data[nfx]  = oldv[p];
                        nfx           = nfx + 1;
                        n             = n + 1;
                        take_mask[p]  = 1'b1;
                    end else begin
                        halt = 1'b1;
                    end
                end else if (cls[p] == CL_FLT) begin
                    if (nfl < LANES) begin
                        fl_valid[nfl] = 1'b1;
                        fl_idx[nfl]   = dst[p];
                        fl_data[nfl]  = oldv[p];
                        nfl           = nfl + 1;
                        n             = n + 1;
                        take_mask[p]  = 1'b1;
                    end else begin
                        halt = 1'b1;
                    end
                end else begin
                    n            = n + 1;
                    take_mask[p] = 1'b1;
                end
            end
        end
        take_n     = CNT_W'(n);
        take_fix_n = CNT_W'(nfx);
    end

endmodule

// File: rtl/rbq_store_buf.sv
// Module: rbq_store_buf
// Holds store address and data per slot and releases at most one store per
// cycle: the oldest unreleased store whose older records have all completed
// without a fault. Discarding needs no action: an unreleased slot is simply
// overwritten by its next issue.
// Assumes: stores are marked complete at issue by the top.
module rbq_store_buf #(
    parameter int DEPTH  = 6,
    parameter int TAG_W  = 3,
    parameter int CNT_W  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              enable,
    input  logic [TAG_W-1:0]  head,
    input  logic [CNT_W-1:0]  occ,
    input  logic [DEPTH-1:0]  is_store,
    input  logic [DEPTH-1:0]  done,
    input  logic [DEPTH-1:0]  fault,
    output logic [DEPTH-1:0]  released,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    logic [DEPTH-1:0][ADDR_W-1:0] sb_addr;
    logic [DEPTH-1:0][DATA_W-1:0] sb_data;
    logic                         sel_ok;
    logic [TAG_W-1:0]             sel_tag;

    // Purpose: find the oldest store behind an all-clean prefix.
    always_comb begin : walk
        logic clean;
        int   p;
        clean   = 1'b1;
        sel_ok  = 1'b0;
        sel_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            p = (int'(head) + i) % DEPTH;
            if (enable && !sel_ok && clean && (i < int'(occ))) begin
                if (is_store[p] && !released[p]) begin
                    sel_ok  = 1'b1;
                    sel_tag = TAG_W'(p);
                end
                clean = done[p] && !fault[p];
            end
        end
    end

    // Purpose: drive the memory write port from the selected slot.
    always_comb begin
        mem_wr_valid = sel_ok;
        mem_wr_addr  = sel_ok ? sb_addr[sel_tag] : '0;
        mem_wr_data  = sel_ok ? sb_data[sel_tag] : '0;
    end

    // Purpose: track which slots have already been released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            released <= '0;
        end else begin
            if (wr_en)  released[wr_tag]  <= 1'b0;
            if (sel_ok) released[sel_tag] <= 1'b1;
        end
    end

    // Purpose: capture store payload at issue (no reset needed).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            sb_addr[wr_tag] <= wr_addr;
            sb_data[wr_tag] <= wr_data;
        end
    end

endmodule

// File: rtl/rb_history_queue.sv
// Module: rb_history_queue
// Top of the rollback queue. Owns per-slot status (occupied, complete,
// fault) and payload (class, destination, prior value), recognises faults
// only at the head, and sequences the rollback through rbq_unwind_pick.
// Assumes: completion reports name occupied, non-store slots. Reports for
// other slots, or during rollback, are dropped.
module rb_history_queue
    import rbq_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int TAG_W   = 3,
    parameter int FIX_MAX = 4,
    parameter int IDX_W   = 5,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int LANES   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue_valid,
    input  logic [1:0]                   issue_class,
    input  logic [IDX_W-1:0]             issue_dst,
    input  logic [DATA_W-1:0]            issue_old,
    input  logic [ADDR_W-1:0]            issue_addr,
    output logic                         issue_ready,
    output logic [TAG_W-1:0]             issue_tag,
    input  logic                         finish_valid,
    input  logic [TAG_W-1:0]             finish_tag,
    input  logic                         finish_exc,
    output logic                         retire_valid,
    output logic [TAG_W-1:0]             retire_tag,
    output logic                         exception_taken,
    output logic [LANES-1:0]             rfx_valid,
    output logic [LANES-1:0][IDX_W-1:0]  rfx_idx,
    output logic [LANES-1:0][DATA_W-1:0] rfx_data,
    output logic [LANES-1:0]             rfl_valid,
    output logic [LANES-1:0][IDX_W-1:0]  rfl_idx,
    output logic [LANES-1:0][DATA_W-1:0] rfl_data,
    output logic                         mem_wr_valid,
    output logic [ADDR_W-1:0]            mem_wr_addr,
    output logic [DATA_W-1:0]            mem_wr_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    qstate_e                      state;
    logic                         unwinding;
    logic [TAG_W-1:0]             head;
    logic [TAG_W-1:0]             tail;
    logic [CNT_W-1:0]             occ;
    logic [CNT_W-1:0]             fix_occ;
    logic                         issue_fire;
    logic                         head_fault;
    logic                         retire;
    logic                         fin_ok;
    logic                         blk;

    logic [DEPTH-1:0]             e_vld;
    logic [DEPTH-1:0]             e_done;
    logic [DEPTH-1:0]             e_exc;
    logic [DEPTH-1:0][1:0]        e_cls;
    logic [DEPTH-1:0][IDX_W-1:0]  e_dst;
    logic [DEPTH-1:0][DATA_W-1:0] e_old;
    logic [DEPTH-1:0]             e_sto;
    logic [DEPTH-1:0]             e_rel;

    logic [CNT_W-1:0]             take_n;
    logic [CNT_W-1:0]             take_fix_n;
    logic [DEPTH-1:0]             take_mask;
    logic [LANES-1:0]             pk_fx_v;
    logic [LANES-1:0][IDX_W-1:0]  pk_fx_i;
    logic [LANES-1:0][DATA_W-1:0] pk_fx_d;
    logic [LANES-1:0]             pk_fl_v;
    logic [LANES-1:0][IDX_W-1:0]  pk_fl_i;
    logic [LANES-1:0][DATA_W-1:0] pk_fl_d;

    // Purpose: per-slot store flag used by the release walk.
    for (genvar g = 0; g < DEPTH; g++) begin : g_sto
        assign e_sto[g] = (e_cls[g] == CL_STO);
    end

    // Purpose: head-of-queue decisions (retire or fault) and issue blocking.
    always_comb begin
        unwinding       = (state == ST_UNWIND);
        head_fault      = !unwinding && (occ != '0) && e_done[head] && e_exc[head];
        retire          = !unwinding && (occ != '0) && e_done[head] && !e_exc[head] &&
                          (!e_sto[head] || e_rel[head]);
        blk             = unwinding || head_fault;
        fin_ok          = !unwinding && finish_valid && (finish_tag < TAG_W'(DEPTH)) &&
                          e_vld[finish_tag] && !e_sto[finish_tag];
        exception_taken = head_fault;
        retire_valid    = retire;
        retire_tag      = head;
        issue_tag       = tail;
    end

    // Purpose: restore lanes are live only while unwinding.
    always_comb begin
        rfx_valid = unwinding ? pk_fx_v : '0;
        rfx_idx   = pk_fx_i;
        rfx_data  = pk_fx_d;
        rfl_valid = unwinding ? pk_fl_v : '0;
        rfl_idx   = pk_fl_i;
        rfl_data  = pk_fl_d;
    end

    rbq_alloc #(
        .DEPTH   (DEPTH),
        .TAG_W   (TAG_W),
        .FIX_MAX (FIX_MAX),
        .CNT_W   (CNT_W)
    ) u_alloc (
        .clk           (clk),
        .rst_n         (rst_n),
        .block         (blk),
        .issue_valid   (issue_valid),
        .issue_is_fix  (issue_class == CL_FIX),
        .retire        (retire),
        .retire_is_fix (e_cls[head] == CL_FIX),
        .unwind        (unwinding),
        .unwind_n      (take_n),
        .unwind_fix_n  (take_fix_n),
        .issue_ready   (issue_ready),
        .issue_fire    (issue_fire),
        .head          (head),
        .tail          (tail),
        .occ           (occ),
        .fix_occ       (fix_occ)
    );

    rbq_unwind_pick #(
        .DEPTH  (DEPTH),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_pick (
        .tail       (tail),
        .occ        (occ),
        .cls        (e_cls),
        .dst        (e_dst),
        .oldv       (e_old),
        .take_n     (take_n),
        .take_fix_n (take_fix_n),
        .take_mask  (take_mask),
        .fx_valid   (pk_fx_v),
        .fx_idx     (pk_fx_i),
        .fx_data    (pk_fx_d),
        .fl_valid   (pk_fl_v),
        .fl_idx     (pk_fl_i),
        .fl_data    (pk_fl_d)
    );

    rbq_store_buf #(
        .DEPTH  (DEPTH),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (issue_fire && (issue_class == CL_STO)),
        .wr_tag       (tail),
        .wr_addr      (issue_addr),
        .wr_data      (issue_old),
        .enable       (!unwinding),
        .head         (head),
        .occ          (occ),
        .is_store     (e_sto),
        .done         (e_done),
        .fault        (e_exc),
        .released     (e_rel),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data)
    );

    // Purpose: run/unwind sequencing; unwinding ends when the last records go.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else if (head_fault)
            state <= ST_UNWIND;
        else if (unwinding && (take_n == occ))
            state <= ST_RUN;
    end

    // Purpose: per-slot status bits (occupied, complete, fault).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld  <= '0;
            e_done <= '0;
            e_exc  <= '0;
        end else begin
            if (retire) e_vld[head] <= 1'b0;
            if (unwinding) e_vld <= e_vld & ~take_mask;
            if (issue_fire) begin
                e_vld[tail]  <= 1'b1;
                e_done[tail] <= (issue_class == CL_STO);
                e_exc[tail]  <= 1'b0;
            end
            if (fin_ok) begin
                e_done[finish_tag] <= 1'b1;
                e_exc[finish_tag]  <= finish_exc;
            end
        end
    end

    // Purpose: capture issue payload into the allocated slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_cls <= '0;
        end else if (issue_fire) begin
            e_cls[tail] <= issue_class;
        end
    end

    // Purpose: payload without reset; only read for occupied slots.
    always_ff @(posedge clk) begin
        if (issue_fire) begin
            e_dst[tail] <= issue_dst;
            e_old[tail] <= issue_old;
        end
    end

endmodule

// File: rtl/rbq_chk.sv
// Module: rbq_chk
// Protocol checker for rb_history_queue, attached through bind below.
// Assumes: connected to the top's internal occupancy and state signals.
module rbq_chk #(
    parameter int DEPTH   = 6,
    parameter int FIX_MAX = 4,
    parameter int CNT_W   = 3,
    parameter int LANES   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unwinding,
    input logic [CNT_W-1:0] occ,
    input logic [CNT_W-1:0] fix_occ,
    input logic             issue_ready,
    input logic             retire_valid,
    input logic             exception_taken,
    input logic [LANES-1:0] rfx_valid,
    input logic [LANES-1:0] rfl_valid,
    input logic             mem_wr_valid
);

    p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    p_fix_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fix_occ <= CNT_W'(FIX_MAX));

    p_retire_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (!unwinding && !exception_taken));

    p_fault_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exception_taken |=> unwinding);

    p_quiet_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !unwinding |-> (rfx_valid == '0 && rfl_valid == '0));

    p_lane_pack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rfx_valid & (rfx_valid + 1'b1)) == '0) &&
        ((rfl_valid & (rfl_valid + 1'b1)) == '0));

    p_issue_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unwinding || exception_taken) |-> !issue_ready);

    p_empty_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unwinding) |-> (occ == '0));

    p_store_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (!unwinding && !exception_taken));

endmodule

bind rb_history_queue rbq_chk #(
    .DEPTH   (DEPTH),
    .FIX_MAX (FIX_MAX),
    .CNT_W   (CNT_W),
    .LANES   (LANES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .unwinding       (unwinding),
    .occ             (occ),
    .fix_occ         (fix_occ),
    .issue_ready     (issue_ready),
    .retire_valid    (retire_valid),
    .exception_taken (exception_taken),
    .rfx_valid       (rfx_valid),
    .rfl_valid       (rfl_valid),
    .mem_wr_valid    (mem_wr_valid)
);

// File: tb/sim_rb_history_queue.sv
`timescale 1ns/1ps
// Bench: directed tests plus a sweep over every fixed/float mix of a full queue.
module sim_rb_history_queue;

    localparam logic [1:0] C_FIX = 2'd0;
    localparam logic [1:0] C_FLT = 2'd1;
    localparam logic [1:0] C_CCB = 2'd2;
    localparam logic [1:0] C_STO = 2'd3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                issue_valid = 1'b0;
    logic [1:0]          issue_class = 2'd0;
    logic [4:0]          issue_dst = '0;
    logic [31:0]         issue_old = '0;
    logic [31:0]         issue_addr = '0;
    logic                issue_ready;
    logic [2:0]          issue_tag;
    logic                finish_valid = 1'b0;
    logic [2:0]          finish_tag = '0;
    logic                finish_exc = 1'b0;
    logic                retire_valid;
    logic [2:0]          retire_tag;
    logic                exception_taken;
    logic [1:0]          rfx_valid;
    logic [1:0][4:0]     rfx_idx;
    logic [1:0][31:0]    rfx_data;
    logic [1:0]          rfl_valid;
    logic [1:0][4:0]     rfl_idx;
    logic [1:0][31:0]    rfl_data;
    logic                mem_wr_valid;
    logic [31:0]         mem_wr_addr;
    logic [31:0]         mem_wr_data;

    rb_history_queue u0 (
        .clk (clk), .rst_n (rst_n),
        .issue_valid (issue_valid), .issue_class (issue_class),
        .issue_dst (issue_dst), .issue_old (issue_old), .issue_addr (issue_addr),
        .issue_ready (issue_ready), .issue_tag (issue_tag),
        .finish_valid (finish_valid), .finish_tag (finish_tag), .finish_exc (finish_exc),
        .retire_valid (retire_valid), .retire_tag (retire_tag),
        .exception_taken (exception_taken),
        .rfx_valid (rfx_valid), .rfx_idx (rfx_idx), .rfx_data (rfx_data),
        .rfl_valid (rfl_valid), .rfl_idx (rfl_idx), .rfl_data (rfl_data),
        .mem_wr_valid (mem_wr_valid), .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data)
    );

    int total = 0;
    int bad   = 0;

    // Monitor state, updated 1 ns after each falling edge.
    int          exc_n, rcyc, blk_bad, mem_n, ret_n, same_n;
    logic [31:0] mem_a [0:7];
    logic [31:0] mem_d [0:7];
    int          ret_tags [0:15];
    logic [31:0] gpr [0:31];
    logic [31:0] fpr [0:31];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        exc_n = 0; rcyc = 0; blk_bad = 0; mem_n = 0; ret_n = 0; same_n = 0;
    endtask

    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (exception_taken) exc_n++;
            if (|rfx_valid || |rfl_valid) begin
                rcyc++;
                if (issue_ready) blk_bad++;
            end
            for (int l = 0; l < 2; l++) if (rfx_valid[l]) gpr[rfx_idx[l]] = rfx_data[l];
            for (int l = 0; l < 2; l++) if (rfl_valid[l]) fpr[rfl_idx[l]] = rfl_data[l];
            if (mem_wr_valid) begin
                if (mem_n < 8) begin mem_a[mem_n] = mem_wr_addr; mem_d[mem_n] = mem_wr_data; end
                mem_n++;
            end
            if (retire_valid) begin
                if (ret_n < 16) ret_tags[ret_n] = int'(retire_tag);
                ret_n++;
                if (mem_wr_valid) same_n++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; issue_valid = 1'b0; finish_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clr_mon();
    endtask

    task automatic issue(input logic [1:0] c, input int dst, input logic [31:0] oldv,
                         input logic [31:0] addr, output int tag, output bit rdy);
        @(negedge clk);
        issue_valid = 1'b1; issue_class = c; issue_dst = 5'(dst);
        issue_old = oldv; issue_addr = addr;
        #1;
        rdy = issue_ready;
        tag = int'(issue_tag);
        @(posedge clk);
        #1;
        issue_valid = 1'b0;
    endtask

    task automatic probe(input logic [1:0] c, output bit rdy);
        @(negedge clk);
        issue_valid = 1'b0; issue_class = c;
        #1;
        rdy = issue_ready;
    endtask

    task automatic finish(input int tag, input bit exc);
        @(negedge clk);
        finish_valid = 1'b1; finish_tag = 3'(tag); finish_exc = exc;
        @(posedge clk);
        #1;
        finish_valid = 1'b0; finish_exc = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int  tag;
        bit  rdy;
        int  mism;
        do_reset();

        // R1: reset state
        probe(C_FIX, rdy);
        chk(rdy == 1'b1, "R1", "ready after reset", rdy, 1);
        chk(!retire_valid && !exception_taken && !mem_wr_valid && rfx_valid == 0 && rfl_valid == 0,
            "R1", "outputs idle after reset",
            {retire_valid, exception_taken, mem_wr_valid}, 0);

        // R3 and R1: fill with condition/branch entries
        mism = 0;
        for (int k = 0; k < 6; k++) begin
            issue(C_CCB, 0, 0, 0, tag, rdy);
            if (tag != k || !rdy) mism++;
        end
        chk(mism == 0, "R3", "sequential tags 0..5", mism, 0);
        probe(C_CCB, rdy);
        chk(rdy == 1'b0, "R1", "full blocks cond/branch", rdy, 0);
        probe(C_FIX, rdy);
        chk(rdy == 1'b0, "R1", "full blocks fixed", rdy, 0);

        // R4: younger completion does not retire
        finish(3, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(ret_n == 0, "R4", "no retire before head completes", ret_n, 0);
        finish(1, 1'b0); finish(0, 1'b0); finish(2, 1'b0);
        finish(5, 1'b0); finish(4, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ret_n == 6, "R4", "all six retire", ret_n, 6);
        mism = 0;
        for (int k = 0; k < 6; k++) if (ret_tags[k] != k) mism++;
        chk(mism == 0, "R4", "retire order", mism, 0);
        issue(C_CCB, 0, 0, 0, tag, rdy);
        chk(tag == 0 && rdy, "R3", "tag wraps to 0", tag, 0);

        // R2: fixed-point limit
        do_reset();
        for (int k = 0; k < 4; k++) issue(C_FIX, k, 0, 0, tag, rdy);
        probe(C_FIX, rdy);
        chk(rdy == 1'b0, "R2", "fifth fixed blocked", rdy, 0);
        probe(C_FLT, rdy);
        chk(rdy == 1'b1, "R2", "float still accepted", rdy, 1);
        issue(C_FLT, 1, 0, 0, tag, rdy);
        chk(rdy == 1'b1 && tag == 4, "R2", "float issued at slot 4", tag, 4);
        finish(0, 1'b0);
        repeat (2) @(posedge clk);
        probe(C_FIX, rdy);
        chk(rdy == 1'b1, "R2", "fixed accepted after a fixed retires", rdy, 1);

        // R9: stores behind an unfinished fixed op, released in order
        do_reset();
        issue(C_FIX, 1, 0, 0, tag, rdy);
        issue(C_STO, 0, 32'hAA, 32'h40, tag, rdy);
        issue(C_STO, 0, 32'hBB, 32'h44, tag, rdy);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_n == 0, "R9", "stores held while older op pending", mem_n, 0);
        finish(0, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mem_n == 2, "R9", "two stores released", mem_n, 2);
        chk(mem_a[0] == 32'h40 && mem_a[1] == 32'h44, "R9", "release order addr0", mem_a[0], 32'h40);
        chk(mem_d[0] == 32'hAA && mem_d[1] == 32'hBB, "R9", "release data0", mem_d[0], 32'hAA);
        chk(same_n == 2, "R9", "release coincides with retire", same_n, 2);
        chk(ret_n == 3, "R4", "retire count with stores", ret_n, 3);

        // R10: store behind a faulting op is discarded
        do_reset();
        issue(C_FIX, 1, 0, 0, tag, rdy);
        issue(C_STO, 0, 32'hCC, 32'h80, tag, rdy);
        finish(0, 1'b1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(mem_n == 0, "R10", "discarded store never written", mem_n, 0);
        chk(exc_n == 1, "R10", "fault taken", exc_n, 1);

        // Sweep over fixed/float mixes of a full queue (R5..R8)
        for (int pat = 0; pat < 64; pat++) begin
            int nflt;
            int fx, fl, ecyc;
            logic [31:0] g0 [0:3];
            logic [31:0] f0 [0:3];
            nflt = $countones(6'(pat));
            if (nflt < 2) continue;
            do_reset();
            for (int r = 0; r < 32; r++) begin gpr[r] = 32'h1000 + r; fpr[r] = 32'h2000 + r; end
            for (int r = 0; r < 4; r++) begin g0[r] = gpr[r]; f0[r] = fpr[r]; end
            for (int k = 0; k < 6; k++) begin
                int d;
                d = (k + pat) % 4;
                if (pat[k]) begin
                    issue(C_FLT, d, fpr[d], 0, tag, rdy);
                    fpr[d] = 32'h5000 + 32'(k * 64 + pat);
                end else begin
                    issue(C_FIX, d, gpr[d], 0, tag, rdy);
                    gpr[d] = 32'h4000 + 32'(k * 64 + pat);
                end
            end
            for (int k = 5; k >= 1; k--) finish(k, 1'b0);
            finish(3, 1'b1);
            @(negedge clk);
            chk(exc_n == 0 && ret_n == 0, "R5", "younger fault ignored while head pending",
                exc_n + ret_n, 0);
            finish(0, 1'b1);
            repeat (10) @(posedge clk);
            @(negedge clk);
            fx = 0; fl = 0; ecyc = 1;
            for (int k = 5; k >= 0; k--) begin
                if (pat[k]) begin
                    if (fl == 2) begin ecyc++; fx = 0; fl = 0; end
                    fl++;
                end else begin
                    if (fx == 2) begin ecyc++; fx = 0; fl = 0; end
                    fx++;
                end
            end
            chk(exc_n == 1, "R5", "fault taken once at head", exc_n, 1);
            chk(rcyc == ecyc, "R7", "rollback cycle count", rcyc, ecyc);
            mism = 0;
            for (int r = 0; r < 4; r++) begin
                if (gpr[r] != g0[r]) mism++;
                if (fpr[r] != f0[r]) mism++;
            end
            chk(mism == 0, "R6", "register state restored", mism, 0);
            chk(blk_bad == 0 && ret_n == 0, "R8", "issue blocked during rollback", blk_bad, 0);
            probe(C_FIX, rdy);
            chk(rdy == 1'b1 && issue_tag == 3'd0, "R8", "empty after rollback, tag at fault slot",
                issue_tag, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule